// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets logic on a single clock read and write an external asynchronous byte-wide static RAM with an 18-bit address. The user side has a request/ready handshake. One request carries an address, write data and a direction flag. The block answers with a one-cycle completion pulse and, for reads, a registered data byte. The memory side drives active-low chip select, output enable and write strobe, plus the address lines. The data bus is split into an output value, a drive-enable and an input value, so that the pad ring can build the tri-state buffer.

The memory's nanosecond limits are turned into whole clock cycles from a clock-period parameter, rounding up with a floor of one cycle. These limits are access time, cycle times, write-strobe width, data setup, address-to-write-end and output release time. Writes always keep output enable high, which allows the shorter strobe minimum. After a read, the bus stays undriven long enough for the memory to release it. Between requests all three controls sit high, which parks the memory in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, and whenever the block is idle, chip select, output enable and write strobe are all high, the data drive-enable is low, and ready is high.
- R2: A request is accepted only when req_i and ready_o are both high at a clock edge. Ready stays low from the accepting edge until completion. done_o is high for exactly one cycle, and ready_o returns high in that same cycle.
- R3: A read holds chip select and output enable low and write strobe high, with a fixed address. It lasts max(ceil(tAA), ceil(tRC)) cycles, with tAA = tRC = 15 ns. rdata_o is sampled at the end of that window and is valid when done_o is high.
- R4: A write holds output enable high and drives chip select and write strobe low together. The low time is C_WP = max(ceil(tPWE=10), ceil(tSD=7), ceil(tAW=10), ceil(tSCE=10), ceil(tWC=15)-1) cycles. Write data is driven for the whole strobe and for one cycle after the strobe rises.
- R5: Counting the accepting edge as 1, done_o is first seen after 1 + C_RD + C_HZ edges for a read and after 2 + C_WP edges for a write. Here C_RD is the read window from R3 and C_HZ = ceil(tHZ = 6 ns).
- R6: The address does not change while chip select stays low. Driven write data does not change while the drive-enable stays high.
- R7: The data bus is never driven while the memory may drive it. That means any cycle with chip select and output enable low and write strobe high, or the cycle that follows one.
- R8: req_i and the request fields have no effect while ready_o is low. A completed operation uses only the values captured at the accepting edge.
- R9: rdata_o changes only at the end of a read. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Request address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Block can accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Data from the last read |
| sram_ce_no | output | 1 | Memory chip select, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_addr_o | output | 18 | Memory address |
| sram_dq_o | output | 8 | Data toward the memory |
| sram_dq_oe_o | output | 1 | Drive-enable for sram_dq_o |
| sram_dq_i | input | 8 | Data from the memory |

## Verification
The bound checker watches the memory pins on every cycle. It covers quiet controls while ready, output enable high under every strobe, and the minimum strobe and read-window lengths, which it measures with counters. It also covers address and write-data stability, and the absence of drive during and just after any cycle where the memory may drive. The following can only be shown by the bench's scenarios, which run against a behavioural memory model:
- the memory contents actually written and read back at the edge addresses;
- that data sampled before the access time would be wrong;
- exact completion latency;
- that requests raised while busy are ignored;
- that rdata_o survives writes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RREC,
    ST_WR,
    ST_WHOLD
  } st_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } pins_t;

  function automatic int ns2cyc(int t_ns, int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int rd_cyc(int t_aa, int t_rc, int clk_ns);
    return max2(ns2cyc(t_aa, clk_ns), ns2cyc(t_rc, clk_ns));
  endfunction

  function automatic int wp_cyc(int t_pwe, int t_sd, int t_aw, int t_sce,
                                int t_wc, int clk_ns);
    int c;
    c = max2(max2(ns2cyc(t_pwe, clk_ns), ns2cyc(t_sd, clk_ns)),
             max2(ns2cyc(t_aw, clk_ns), ns2cyc(t_sce, clk_ns)));
    return max2(c, ns2cyc(t_wc, clk_ns) - 1);
  endfunction

  function automatic pins_t pins_of(st_e s);
    pins_t p;
    case (s)
      ST_RD:    p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
      ST_WR:    p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
      ST_WHOLD: p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
      default:  p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int C_RD  = 2,
  parameter int C_HZ  = 1,
  parameter int C_WP  = 1,
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             expired_i,
  output st_e              st_d_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             done_o
);
  st_e  st_q, st_d;
  logic done_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (req_i) st_d = wr_i ? ST_WR : ST_RD;
      ST_RD:    if (expired_i) st_d = ST_RREC;
      ST_RREC:  if (expired_i) st_d = ST_IDLE;
      ST_WR:    if (expired_i) st_d = ST_WHOLD;
      ST_WHOLD: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_d)
      ST_RD:   load_val_o = CNT_W'(C_RD - 1);
      ST_RREC: load_val_o = CNT_W'(C_HZ - 1);
      ST_WR:   load_val_o = CNT_W'(C_WP - 1);
      default: load_val_o = '0;
    endcase
  end

  assign load_o    = (st_d != st_q);
  assign accept_o  = (st_q == ST_IDLE) && req_i;
  assign capture_o = (st_q == ST_RD) && expired_i;
  assign ready_o   = (st_q == ST_IDLE);
  assign st_d_o    = st_d;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               st_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ce_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  pins_t             pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  // pins registered from the next state so they change glitch-free at the edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= pins_of(ST_IDLE);
    else         pins_q <= pins_of(st_d_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  assign ce_no   = pins_q.ce_n;
  assign oe_no   = pins_q.oe_n;
  assign we_no   = pins_q.we_n;
  assign dq_oe_o = pins_q.drive;
  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AA_NS       = 15,
  parameter int T_RC_NS       = 15,
  parameter int T_WC_NS       = 15,
  parameter int T_PWE_NS      = 10,
  parameter int T_SD_NS       = 7,
  parameter int T_AW_NS       = 10,
  parameter int T_SCE_NS      = 10,
  parameter int T_HZ_NS       = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int C_RD  = rd_cyc(T_AA_NS, T_RC_NS, CLK_PERIOD_NS);
  localparam int C_HZ  = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int C_WP  = wp_cyc(T_PWE_NS, T_SD_NS, T_AW_NS, T_SCE_NS,
                                T_WC_NS, CLK_PERIOD_NS);
  localparam int C_MAX = max2(max2(C_RD, C_WP), C_HZ);
  localparam int CNT_W = $clog2(C_MAX + 1);

  st_e              st_d;
  logic             load, expired, accept, capture;
  logic [CNT_W-1:0] load_val;

  sram_ctrl_fsm #(
    .C_RD (C_RD),
    .C_HZ (C_HZ),
    .C_WP (C_WP),
    .CNT_W(CNT_W)
  ) fsm_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .wr_i      (wr_i),
    .expired_i (expired),
    .st_d_o    (st_d),
    .load_o    (load),
    .load_val_o(load_val),
    .accept_o  (accept),
    .capture_o (capture),
    .ready_o   (ready_o),
    .done_o    (done_o)
  );

  sram_ctrl_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .expired_o (expired)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_d_i   (st_d),
    .accept_i (accept),
    .capture_i(capture),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .dq_i     (sram_dq_i),
    .rdata_o  (rdata_o),
    .ce_no    (sram_ce_no),
    .oe_no    (sram_oe_no),
    .we_no    (sram_we_no),
    .addr_o   (sram_addr_o),
    .dq_o     (sram_dq_o),
    .dq_oe_o  (sram_dq_oe_o)
  );
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AA_NS       = 15,
  parameter int T_RC_NS       = 15,
  parameter int T_WC_NS       = 15,
  parameter int T_PWE_NS      = 10,
  parameter int T_SD_NS       = 7,
  parameter int T_AW_NS       = 10,
  parameter int T_SCE_NS      = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              sram_ce_no,
  input logic              sram_oe_no,
  input logic              sram_we_no,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o
);
  localparam int K_RD = rd_cyc(T_AA_NS, T_RC_NS, CLK_PERIOD_NS);
  localparam int K_WP = wp_cyc(T_PWE_NS, T_SD_NS, T_AW_NS, T_SCE_NS,
                               T_WC_NS, CLK_PERIOD_NS);

  logic mem_reads;
  assign mem_reads = !sram_ce_no && !sram_oe_no && sram_we_no;

  int wl_cnt, rd_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wl_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      wl_cnt <= !sram_we_no ? ((wl_cnt < K_WP) ? wl_cnt + 1 : wl_cnt) : 0;
      rd_cnt <= mem_reads   ? ((rd_cnt < K_RD) ? rd_cnt + 1 : rd_cnt) : 0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && sram_oe_no && sram_we_no && !sram_dq_oe_o));

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_with_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  assert_read_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> (rd_cnt >= K_RD));

  assert_write_oe_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (sram_oe_no && !sram_ce_no && sram_dq_oe_o));

  assert_write_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (wl_cnt >= K_WP));

  assert_hold_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o);

  assert_addr_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));

  assert_wdata_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  assert_no_contention_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_reads |-> !sram_dq_oe_o);

  assert_turnaround_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mem_reads) |-> !sram_dq_oe_o);
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_AA_NS      (T_AA_NS),
  .T_RC_NS      (T_RC_NS),
  .T_WC_NS      (T_WC_NS),
  .T_PWE_NS     (T_PWE_NS),
  .T_SD_NS      (T_SD_NS),
  .T_AW_NS      (T_AW_NS),
  .T_SCE_NS     (T_SCE_NS)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .sram_ce_no  (sram_ce_no),
  .sram_oe_no  (sram_oe_no),
  .sram_we_no  (sram_we_no),
  .sram_addr_o (sram_addr_o),
  .sram_dq_o   (sram_dq_o),
  .sram_dq_oe_o(sram_dq_oe_o)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAA = 15, TRC = 15, TWC = 15, TPWE = 10, TSD = 7,
                 TAW = 10, TSCE = 10, THZ = 6;

  function automatic int cyc(int t);
    int c;
    c = (t + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_RD = mx(cyc(TAA), cyc(TRC));
  localparam int EXP_HZ = cyc(THZ);
  localparam int EXP_WP = mx(mx(mx(cyc(TPWE), cyc(TSD)), mx(cyc(TAW), cyc(TSCE))),
                             cyc(TWC) - 1);
  localparam int LAT_RD = 1 + EXP_RD + EXP_HZ;
  localparam int LAT_WR = 2 + EXP_WP;

  logic        clk, rst_n;
  logic        req, wr;
  logic [17:0] addr;
  logic [7:0]  wdata;
  logic        ready, done;
  logic [7:0]  rdata;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [17:0] m_addr;
  logic [7:0]  dq_o, dq_i;

  int checks = 0, errors = 0;
  bit finished = 0;

  sram_async_ctrl #(.CLK_PERIOD_NS(CLK_PERIOD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .sram_ce_no(ce_n), .sram_oe_no(oe_n), .sram_we_no(we_n),
    .sram_addr_o(m_addr), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] init_val(logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {a[17:16], 6'h15};
  endfunction

  logic [7:0] model_mem [logic [17:0]];
  logic [7:0] exp_mem   [logic [17:0]];

  function automatic logic [7:0] model_rd(logic [17:0] a);
    return model_mem.exists(a) ? model_mem[a] : init_val(a);
  endfunction
  function automatic logic [7:0] exp_rd(logic [17:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
  endfunction

  task automatic check(bit ok, string req_tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // behavioural memory, evaluated mid-cycle
  bit          rd_prev = 0, pend = 0;
  int          rd_cnt = 0, wl_cnt = 0;
  logic [17:0] rd_addr = '0, p_addr = '0;
  logic [7:0]  p_data = '0;
  initial dq_i = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      bit rd_now, wr_now;
      rd_now = !ce_n && !oe_n && we_n;
      wr_now = !ce_n && !we_n;
      if (dq_oe) check(!(rd_now || rd_prev), "R7", "drive while memory drives",
                       int'(rd_prev), 0);
      if (rd_now) begin
        rd_cnt  = (rd_prev && m_addr == rd_addr) ? rd_cnt + 1 : 1;
        rd_addr = m_addr;
        dq_i <= ((rd_cnt - 1) * CLK_PERIOD + CLK_PERIOD / 2 >= TAA)
                ? model_rd(m_addr) : ~model_rd(m_addr);
      end else begin
        rd_cnt = 0;
        dq_i <= 8'h00;
      end
      if (wr_now) begin
        if (!oe_n || !dq_oe)
          check(0, "R4", "write with oe low or bus undriven", {oe_n, dq_oe}, 2'b11);
        pend   = 1;
        p_addr = m_addr;
        p_data = dq_o;
        wl_cnt++;
      end else if (pend) begin
        check(wl_cnt >= EXP_WP, "R4", "write strobe cycles", wl_cnt, EXP_WP);
        model_mem[p_addr] = p_data;
        pend   = 0;
        wl_cnt = 0;
      end
      rd_prev = rd_now;
    end
  end

  logic [7:0] last_rd = 8'h00;

  task automatic run_op(bit w, logic [17:0] a, logic [7:0] d, bit noise);
    int n;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    n = 1;
    if (!noise) req = 1'b0;
    while (!done && n < 64) begin
      check(!ready, "R2", "ready low while busy", int'(ready), 0);
      if (noise) begin  // R8 stimulus
        wr    = 1'($urandom);
        addr  = 18'($urandom);
        wdata = 8'($urandom);
      end
      @(negedge clk);
      n++;
    end
    req = 1'b0;
    check(n == (w ? LAT_WR : LAT_RD), "R5", "completion latency", n, w ? LAT_WR : LAT_RD);
    check(ready, "R2", "ready with done", int'(ready), 1);
    if (w) begin
      exp_mem[a] = d;
      check(rdata == last_rd, "R9", "rdata kept across write", rdata, last_rd);
    end else begin
      check(rdata == exp_rd(a), noise ? "R8" : "R3", "read data", rdata, exp_rd(a));
      last_rd = exp_rd(a);
    end
    @(negedge clk);
    check(!done, "R2", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] pool [6];
    void'($urandom(32'd4711));
    pool[0] = 18'h00000; pool[1] = 18'h3FFFF; pool[2] = 18'h15555;
    pool[3] = 18'h2AAAA; pool[4] = 18'h00001; pool[5] = 18'h20000;
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check(ce_n && oe_n && we_n && !dq_oe && ready && !done, "R1", "reset state",
          {ce_n, oe_n, we_n, dq_oe, ready, done}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_n && oe_n && we_n && !dq_oe && ready, "R1", "idle after reset",
          {ce_n, oe_n, we_n, dq_oe, ready}, 5'b11101);

    // directed corners
    run_op(0, 18'h00000, 8'h00, 0);              // R3 untouched location
    run_op(1, 18'h00000, 8'hA5, 0);              // R4
    run_op(1, 18'h3FFFF, 8'h3C, 0);
    run_op(0, 18'h3FFFF, 8'h00, 0);
    run_op(1, 18'h00000, 8'h5A, 0);              // R7 write right after read
    run_op(0, 18'h00000, 8'h00, 0);
    run_op(0, 18'h3FFFF, 8'h00, 0);              // back-to-back reads
    run_op(1, 18'h12345, 8'hFF, 1);              // R8 noise while busy
    run_op(0, 18'h12345, 8'h00, 1);

    for (int i = 0; i < 120; i++) begin
      bit          w;
      logic [17:0] a;
      w = 1'($urandom);
      a = ($urandom % 3 == 0) ? 18'($urandom) : pool[$urandom % 6];
      run_op(w, a, 8'($urandom), ($urandom % 5) == 0);
    end

    @(negedge clk);
    check(ce_n && oe_n && we_n && !dq_oe && ready, "R1", "idle at end",
          {ce_n, oe_n, we_n, dq_oe, ready}, 5'b11101);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule